// File: doc/BRIEF.md
# Packed SIMD integer arithmetic unit

This execution unit takes one 32-bit instruction word and two 64-bit source operands. Each source is the value of an even/odd pair of 32-bit registers. The unit decodes the word. When the word is one of the packed vector forms, the unit splits both operands into lanes of 8, 16 or 32 bits and applies one lane-wise operation: add, subtract, unsigned multiply or signed multiply. The packed 64-bit result and the decode flags appear one clock after the request.

A single 64-bit datapath serves all three lane sizes. A one-hot size code in the instruction chooses how the datapath is partitioned. The vector forms reuse the secondary opcode of the matching scalar operation, and they are told apart from the scalar forms by two marker fields in the low half of the word. The register file, the condition codes and the pipeline control sit outside this block. They consume the registered result and the flags.

Top module: `psimd_unit`

## Requirements
- R1: A word is a vector form (`vec_o`=1) only when all of the following hold:
  - bits 31:30 are 2'b10;
  - bit 13 is 0;
  - bits 6:5 are 2'b10;
  - bits 24:19 are one of 6'b000000 (add), 6'b000100 (subtract), 6'b001010 (unsigned multiply) or 6'b001011 (signed multiply).

  Any other word gives `vec_o`=0, `illegal_size_o`=0, `bad_reg_o`=0 and a zero result.
- R2: The size code is bits 9:7. Code 3'b001 selects eight 8-bit lanes, 3'b010 selects four 16-bit lanes and 3'b100 selects two 32-bit lanes. Lane 0 sits in the least significant bits.
- R3: Add wraps modulo the lane width, and no carry passes into the next lane.
- R4: Subtract computes a minus b per lane, wrapping modulo the lane width, and no borrow passes into the next lane.
- R5: Unsigned multiply returns the low lane-width bits of each lane's full unsigned product.
- R6: Signed multiply returns the low lane-width bits of each lane's full two's-complement product.
- R7: A vector form with any size code other than the three legal ones sets `illegal_size_o`=1 and returns a zero result.
- R8: A vector form with an odd register number sets `bad_reg_o`=1. The register fields are rd in bits 29:25, rs1 in bits 18:14 and rs2 in bits 4:0, so the check is on bit 25, 14 or 0. The result is still computed.
- R9: The result and the flags are registered. A request taken with `valid_i`=1 at a clock edge appears with `valid_o`=1 after that edge. When `valid_i` is 0, `valid_o` goes low and `result_o` holds its value.
- R10: After reset, `valid_o`, `result_o`, `vec_o`, `illegal_size_o` and `bad_reg_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 64 | First source (rs1 pair) |
| src_b_i | input | 64 | Second source (rs2 pair) |
| valid_o | output | 1 | Result present, one cycle after request |
| result_o | output | 64 | Packed lane result |
| vec_o | output | 1 | Word decoded as a vector form |
| illegal_size_o | output | 1 | Vector form with an illegal size code |
| bad_reg_o | output | 1 | Vector form naming an odd register |

## Verification
The unit holds no state apart from the output register, so any fault shows on the very next `valid_o` cycle. A wrong size select shows as lane results that match a different partition. A carry or borrow leaking across a boundary corrupts exactly the lane above the one that overflowed. A slip in the opcode or marker decode shows as a `vec_o` flag or a zero result that disagrees with the word. The operands are chosen so that every lane boundary overflows and the signed and unsigned products differ in their high halves. A truncation at the wrong position therefore changes the visible result in the same cycle.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  localparam int DATA_W    = 64;
  localparam int INSTR_W   = 32;
  localparam int BASE_W    = 8;
  localparam int NUM_SIZES = 3;

  typedef enum logic [1:0] {
    VOP_ADD  = 2'd0,
    VOP_SUB  = 2'd1,
    VOP_UMUL = 2'd2,
    VOP_SMUL = 2'd3
  } vop_e;

  // secondary opcodes shared with the scalar forms
  localparam logic [5:0] OP3_ADD  = 6'b000000;
  localparam logic [5:0] OP3_SUB  = 6'b000100;
  localparam logic [5:0] OP3_UMUL = 6'b001010;
  localparam logic [5:0] OP3_SMUL = 6'b001011;

  typedef struct packed {
    logic                 hit;
    vop_e                 op;
    logic [NUM_SIZES-1:0] size_sel;
    logic                 illegal;
    logic                 bad_reg;
  } vdec_t;
endpackage

// File: rtl/psimd_decode.sv
module psimd_decode
  import psimd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output vdec_t              dec_o
);
  logic [1:0] fmt;
  logic [5:0] op3;
  logic [2:0] size_code;
  logic       op_known;
  vop_e       op;

  assign fmt       = instr_i[31:30];
  assign op3       = instr_i[24:19];
  assign size_code = instr_i[9:7];

  always_comb begin
    op_known = 1'b1;
    op       = VOP_ADD;
    unique case (op3)
      OP3_ADD:  op = VOP_ADD;
      OP3_SUB:  op = VOP_SUB;
      OP3_UMUL: op = VOP_UMUL;
      OP3_SMUL: op = VOP_SMUL;
      default:  op_known = 1'b0;
    endcase
  end

  logic hit;
  logic size_ok;
  assign hit     = (fmt == 2'b10) && !instr_i[13] && (instr_i[6:5] == 2'b10) && op_known;
  assign size_ok = (size_code == 3'b001) || (size_code == 3'b010) || (size_code == 3'b100);

  always_comb begin
    dec_o          = '0;
    dec_o.hit      = hit;
    dec_o.op       = op;
    dec_o.illegal  = hit && !size_ok;
    dec_o.size_sel = (hit && size_ok) ? size_code[NUM_SIZES-1:0] : '0;
    dec_o.bad_reg  = hit && (instr_i[25] | instr_i[14] | instr_i[0]);
  end

  // R2
  always_comb begin
    size_sel_onehot_chk: assert ($onehot0(dec_o.size_sel));
  end
endmodule

// File: rtl/psimd_lanes.sv
module psimd_lanes
  import psimd_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int WORD_W = DATA_W
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  vop_e              op_i,
  output logic [WORD_W-1:0] res_o
);
  localparam int NUM_LANES = WORD_W / LANE_W;
  localparam int PROD_W    = 2 * LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic        [LANE_W-1:0] la, lb, lr;
    logic        [PROD_W-1:0] uprod;
    logic signed [PROD_W-1:0] sprod;

    assign la    = a_i[l*LANE_W +: LANE_W];
    assign lb    = b_i[l*LANE_W +: LANE_W];
    assign uprod = la * lb;
    assign sprod = $signed(la) * $signed(lb);

    always_comb begin
      unique case (op_i)
        VOP_ADD:  lr = la + lb;
        VOP_SUB:  lr = la - lb;
        VOP_UMUL: lr = uprod[LANE_W-1:0];
        default:  lr = sprod[LANE_W-1:0];
      endcase
    end

    assign res_o[l*LANE_W +: LANE_W] = lr;

    // R4
    always_comb begin
      if (op_i == VOP_SUB) begin
        sub_inverse_chk: assert (LANE_W'(lr + lb) == la);
      end
    end
  end
endmodule

// File: rtl/psimd_unit.sv
module psimd_unit
  import psimd_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [31:0]  instr_i,
  input  logic [63:0]  src_a_i,
  input  logic [63:0]  src_b_i,
  output logic         valid_o,
  output logic [63:0]  result_o,
  output logic         vec_o,
  output logic         illegal_size_o,
  output logic         bad_reg_o
);
  vdec_t dec;

  psimd_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  logic [DATA_W-1:0] part_res [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    psimd_lanes #(
      .LANE_W (BASE_W << k),
      .WORD_W (DATA_W)
    ) u_lanes (
      .a_i   (src_a_i),
      .b_i   (src_b_i),
      .op_i  (dec.op),
      .res_o (part_res[k])
    );
  end

  // AND-OR select; no select means zero
  logic [DATA_W-1:0] sel_res;
  always_comb begin
    sel_res = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      sel_res |= part_res[k] & {DATA_W{dec.size_sel[k]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      result_o       <= '0;
      vec_o          <= 1'b0;
      illegal_size_o <= 1'b0;
      bad_reg_o      <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o       <= sel_res;
        vec_o          <= dec.hit;
        illegal_size_o <= dec.illegal;
        bad_reg_o      <= dec.bad_reg;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  // R7
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_size_o) |-> (result_o == '0));
  // R1
  nohit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !vec_o) |-> (result_o == '0 && !illegal_size_o && !bad_reg_o));
endmodule

// File: tb/tb_psimd_unit.sv
module tb_psimd_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic        valid_o, vec_o, illegal_size_o, bad_reg_o;
  logic [63:0] result_o;

  always #2 clk_i = ~clk_i;

  psimd_unit dut (
    .clk_i, .rst_ni, .valid_i, .instr_i, .src_a_i, .src_b_i,
    .valid_o, .result_o, .vec_o, .illegal_size_o, .bad_reg_o
  );

  typedef struct {
    logic [63:0] res;
    logic        vec, ill, bad;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [5:0] C_ADD = 6'b000000, C_SUB = 6'b000100,
                         C_UMUL = 6'b001010, C_SMUL = 6'b001011;

  function automatic logic [31:0] mk(logic [5:0] op3, logic [2:0] sz,
                                     logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2,
                                     logic ibit, logic [1:0] mk65);
    return {2'b10, rd, op3, rs1, ibit, 3'b000, sz, mk65, rs2};
  endfunction

  function automatic logic [63:0] model(logic [5:0] op3, logic [2:0] sz,
                                        logic [63:0] a, logic [63:0] b);
    int w;
    logic [63:0] m, r, x, y, p;
    w = (sz == 3'b001) ? 8 : (sz == 3'b010) ? 16 : 32;
    m = (64'h1 << w) - 64'h1;
    r = '0;
    for (int i = 0; i < 64 / w; i++) begin
      x = (a >> (i * w)) & m;
      y = (b >> (i * w)) & m;
      case (op3)
        C_ADD:  p = x + y;
        C_SUB:  p = x - y;
        C_UMUL: p = x * y;
        default: begin
          if (x[w-1]) x = x | ~m;
          if (y[w-1]) y = y | ~m;
          p = x * y;
        end
      endcase
      r = r | ((p & m) << (i * w));
    end
    return r;
  endfunction

  task automatic drive(logic [31:0] ins, logic [63:0] a, logic [63:0] b, exp_t e);
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = ins; src_a_i = a; src_b_i = b;
    exp_q.push_back(e);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic vec(string tag, logic [5:0] op3, logic [2:0] sz, logic [63:0] a, logic [63:0] b);
    exp_t e;
    e.res = model(op3, sz, a, b); e.vec = 1; e.ill = 0; e.bad = 0; e.tag = tag;
    drive(mk(op3, sz, 5'd2, 5'd4, 5'd6, 1'b0, 2'b10), a, b, e);
  endtask

  task automatic final_report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: pops one expected item per result
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected valid_o act=1 exp=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (result_o !== e.res || vec_o !== e.vec || illegal_size_o !== e.ill || bad_reg_o !== e.bad) begin
          fails++;
          $display("FAIL %s act=%h/%b%b%b exp=%h/%b%b%b", e.tag,
                   result_o, vec_o, illegal_size_o, bad_reg_o, e.res, e.vec, e.ill, e.bad);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    final_report();
  end

  initial begin
    exp_t e;
    logic [63:0] held;
    #1;
    checks++;
    if (valid_o !== 0 || result_o !== 0 || vec_o !== 0 || illegal_size_o !== 0 || bad_reg_o !== 0) begin
      fails++;
      $display("FAIL R10 reset act=%b%h%b%b%b exp=0", valid_o, result_o, vec_o, illegal_size_o, bad_reg_o);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 R3 lane partitions with cross-boundary overflow
    vec("R3 add8",  C_ADD, 3'b001, 64'hFF80_7F01_FFFF_0080, 64'h0180_0101_0001_FF80);
    vec("R3 add16", C_ADD, 3'b010, 64'hFFFF_8000_7FFF_0001, 64'h0001_8000_0001_FFFF);
    vec("R3 add32", C_ADD, 3'b100, 64'hFFFF_FFFF_1234_5678, 64'h0000_0001_EDCB_A988);
    vec("R2 add8 lane0", C_ADD, 3'b001, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003);
    // R4
    vec("R4 sub8",  C_SUB, 3'b001, 64'h0001_0200_8000_0010, 64'h0102_0001_0180_FF20);
    vec("R4 sub16", C_SUB, 3'b010, 64'h0000_0001_8000_1234, 64'h0001_0002_0001_4321);
    vec("R4 sub32", C_SUB, 3'b100, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0002);
    // R5
    vec("R5 umul8",  C_UMUL, 3'b001, 64'hFF10_0203_80FF_7F11, 64'hFF10_0405_02FF_0313);
    vec("R5 umul16", C_UMUL, 3'b010, 64'hFFFF_1234_0100_8001, 64'hFFFF_0010_0100_0003);
    vec("R5 umul32", C_UMUL, 3'b100, 64'hFFFF_FFFF_0001_0001, 64'h0000_0003_0001_FFFF);
    // R6
    vec("R6 smul8",  C_SMUL, 3'b001, 64'hFF80_7F81_FE03_0910, 64'h0280_7F81_FD05_F710);
    vec("R6 smul16", C_SMUL, 3'b010, 64'hFFFF_8000_7FFF_F00D, 64'hFFFE_0002_7FFF_0123);
    vec("R6 smul32", C_SMUL, 3'b100, 64'h8000_0001_FFFF_FFFE, 64'h8000_0001_0000_0003);

    // R7 illegal size codes
    foreach (e.tag[i]) ;
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2 || s == 4) continue;
      e.res = '0; e.vec = 1; e.ill = 1; e.bad = 0; e.tag = $sformatf("R7 size=%0d", s);
      drive(mk(C_ADD, 3'(s), 5'd0, 5'd0, 5'd0, 1'b0, 2'b10), 64'hFFFF, 64'h1, e);
    end

    // R8 odd registers, result still computed
    e.res = model(C_ADD, 3'b001, 64'h0101, 64'h0202); e.vec = 1; e.ill = 0; e.bad = 1;
    e.tag = "R8 odd rd";
    drive(mk(C_ADD, 3'b001, 5'd3, 5'd2, 5'd4, 1'b0, 2'b10), 64'h0101, 64'h0202, e);
    e.tag = "R8 odd rs1";
    drive(mk(C_ADD, 3'b001, 5'd2, 5'd5, 5'd4, 1'b0, 2'b10), 64'h0101, 64'h0202, e);
    e.tag = "R8 odd rs2";
    drive(mk(C_ADD, 3'b001, 5'd2, 5'd2, 5'd7, 1'b0, 2'b10), 64'h0101, 64'h0202, e);

    // R1 non-vector words
    e.res = '0; e.vec = 0; e.ill = 0; e.bad = 0;
    e.tag = "R1 bit13 set";
    drive(mk(C_ADD, 3'b001, 5'd2, 5'd2, 5'd2, 1'b1, 2'b10), 64'h1, 64'h1, e);
    e.tag = "R1 marker 01";
    drive(mk(C_ADD, 3'b001, 5'd2, 5'd2, 5'd2, 1'b0, 2'b01), 64'h1, 64'h1, e);
    e.tag = "R1 op3 other";
    drive(mk(6'b000001, 3'b001, 5'd2, 5'd2, 5'd2, 1'b0, 2'b10), 64'h1, 64'h1, e);
    e.tag = "R1 fmt 11";
    drive({2'b11, mk(C_ADD, 3'b001, 5'd2, 5'd2, 5'd2, 1'b0, 2'b10)[29:0]}, 64'h1, 64'h1, e);

    // R9 back-to-back then hold
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = mk(C_ADD, 3'b100, 5'd2, 5'd2, 5'd2, 1'b0, 2'b10);
    src_a_i = 64'h1; src_b_i = 64'h2;
    e.res = 64'h3; e.vec = 1; e.ill = 0; e.bad = 0; e.tag = "R9 back2back a";
    exp_q.push_back(e);
    @(negedge clk_i);
    src_a_i = 64'h10; src_b_i = 64'h20;
    e.res = 64'h30; e.tag = "R9 back2back b";
    exp_q.push_back(e);
    @(negedge clk_i);
    valid_i = 1'b0; src_a_i = 64'hDEAD; src_b_i = 64'hBEEF;
    @(negedge clk_i);
    #1;
    held = result_o;
    repeat (3) @(negedge clk_i);
    #1;
    checks++;
    if (valid_o !== 0 || result_o !== held || held !== 64'h30) begin
      fails++;
      $display("FAIL R9 hold act=%b/%h exp=0/%h", valid_o, result_o, 64'h30);
    end
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 missing results act=%0d exp=0", exp_q.size());
    end
    final_report();
  end
endmodule